// File: doc/BRIEF.md
# Configurable Interrupt Trigger Capture

This block turns a bank of interrupt request lines into a raw pending vector. It samples every line once per clock. Each line has its own trigger setting. A line can be level-sensitive with a chosen active polarity, sensitive to one edge direction, or sensitive to both edges. For edge detection the block keeps the level each line had in the previous cycle. Bits captured from edges stay set until a write-one-to-clear vector removes them.

Three configuration vectors are held in registers inside the block. They start from fixed reset patterns, and a single load strobe replaces all three at once. A separate controller uses the two outputs. The first is the raw pending vector. The second is an edge-status view, which holds only the pending bits of edge-sensed lines. That controller does the bus decoding, the enable masking and the routing to interrupt outputs. All inputs are assumed to be synchronous to the clock already.

Top module: `irq_trigger_capture`

## Requirements
- R1: A line whose sense bit is 1 is level-sensitive. Its raw bit copies the line when its polarity bit is 1 and the inverted line when its polarity bit is 0, and it follows the line every cycle.
- R2: A line with sense 0 and dual-edge bit 1 sets its raw bit whenever its sampled level differs from the level stored for the previous cycle, on both rising and falling changes.
- R3: A line with sense 0, dual-edge 0 and polarity 1 sets its raw bit only on a 0-to-1 change of level.
- R4: A line with sense 0, dual-edge 0 and polarity 0 sets its raw bit only on a 1-to-0 change of level.
- R5: Every line stores its sampled level each cycle as the previous level, whatever its mode. A line that sat high in level mode and then switches to rising-edge mode captures nothing until it falls and rises again.
- R6: The clear vector drops a raw bit only when that bit is 1 in the clear vector and the line is edge-sensed. Raw bits of level-sensed lines are unaffected by the clear vector.
- R7: The edge-status output always equals the raw vector ANDed with the inverse of the current sense vector.
- R8: After reset, raw and edge-status are 0 and the previous levels are 0. The configuration resets to sense 0x1F07FFF8FFFF, dual-edge 0xF800070000 and polarity 0x5F07FFF8FFFF (bit n belongs to line n).
- R9: A raw bit captured from an edge stays set in later cycles that bring no new edge and no clear.
- R10: When an edge capture and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: When the load strobe is high, all three configuration vectors take the new values at that clock edge. The raw update of that same edge still uses the old configuration, and the new configuration governs from the next edge on. Outputs change one clock after the inputs they reflect are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_LINES | Interrupt request lines, already synchronous |
| cfg_load | input | 1 | Load strobe for the three configuration vectors |
| cfg_sense_in | input | N_LINES | New sense vector (1 = level) |
| cfg_both_in | input | N_LINES | New dual-edge vector (1 = both edges) |
| cfg_pol_in | input | N_LINES | New polarity vector (1 = high / rising) |
| edge_clr | input | N_LINES | Write-one-to-clear vector for edge pending bits |
| raw_pend | output | N_LINES | Raw pending vector |
| edge_stat | output | N_LINES | Pending bits of edge-sensed lines only |

## Verification
The hardest situation to reach is a clear landing in the very cycle in which the same line produces a new edge. A line first captures one edge. The stimulus then drives the opposite edge on that dual-edge line in the same cycle that the clear vector targets it. A second hard case comes from mode changes after a long history in another mode. The bench loads new configurations while lines are held high, so the stored previous levels must suppress false captures. A reference model in the bench tracks the stored levels and the configuration, including the one-edge lag after a load.

// File: rtl/trig_capture_pkg.sv
`timescale 1ns/1ps
package trig_capture_pkg;

  localparam int unsigned TC_LINES = 51;

  localparam logic [63:0] TC_SENSE_RST = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [63:0] TC_BOTH_RST  = 64'h0000_00F8_0007_0000;
  localparam logic [63:0] TC_POL_RST   = 64'h0000_5F07_FFF8_FFFF;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_DUAL  = 2'd1,
    TRIG_RISE  = 2'd2,
    TRIG_FALL  = 2'd3
  } trig_mode_e;

  function automatic trig_mode_e trig_mode(input logic sense, input logic both,
                                           input logic pol);
    if (sense)     return TRIG_LEVEL;
    else if (both) return TRIG_DUAL;
    else if (pol)  return TRIG_RISE;
    else           return TRIG_FALL;
  endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
`timescale 1ns/1ps
module trig_cfg_regs
  import trig_capture_pkg::*;
#(
  parameter int unsigned      N_LINES   = TC_LINES,
  parameter logic [N_LINES-1:0] SENSE_RST = TC_SENSE_RST[N_LINES-1:0],
  parameter logic [N_LINES-1:0] BOTH_RST  = TC_BOTH_RST[N_LINES-1:0],
  parameter logic [N_LINES-1:0] POL_RST   = TC_POL_RST[N_LINES-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [N_LINES-1:0] sense_in,
  input  logic [N_LINES-1:0] both_in,
  input  logic [N_LINES-1:0] pol_in,
  output logic [N_LINES-1:0] sense_q,
  output logic [N_LINES-1:0] both_q,
  output logic [N_LINES-1:0] pol_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= SENSE_RST;
      both_q  <= BOTH_RST;
      pol_q   <= POL_RST;
    end else if (load) begin
      sense_q <= sense_in;
      both_q  <= both_in;
      pol_q   <= pol_in;
    end
  end

  // R11: a load strobe replaces all three vectors at the next edge
  assert_cfg_load_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (sense_q == $past(sense_in)) && (both_q == $past(both_in))
             && (pol_q == $past(pol_in)));

  // R11: without a strobe the configuration holds
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sense_q) && $stable(both_q) && $stable(pol_q));

endmodule

// File: rtl/trig_line.sv
`timescale 1ns/1ps
module trig_line
  import trig_capture_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  input  logic sense,
  input  logic both,
  input  logic pol,
  output logic raw_q,
  output logic raw_d
);

  logic       prev_q;
  logic       hit;
  trig_mode_e mode;

  always_comb begin
    mode = trig_mode(sense, both, pol);
    unique case (mode)
      TRIG_LEVEL: hit = pol ? lvl : !lvl;
      TRIG_DUAL:  hit = lvl ^ prev_q;
      TRIG_RISE:  hit = lvl & !prev_q;
      TRIG_FALL:  hit = !lvl & prev_q;
    endcase
    if (mode == TRIG_LEVEL) raw_d = hit;
    else                    raw_d = hit | (raw_q & !clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      prev_q <= lvl;
    end
  end

  // R1: level-sensed raw bit follows the line with the chosen polarity
  assert_level_track_R1: assert property (@(posedge clk) disable iff (rst)
    sense |=> raw_q == ($past(pol) ? $past(lvl) : !$past(lvl)));

  // R5: the previous level is the level sampled one edge earlier
  assert_prev_level_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prev_q == $past(lvl));

  // R6: a clear with no new edge drops an edge-sensed bit
  assert_edge_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!sense && clr && !hit) |=> !raw_q);

  // R9: a captured edge bit holds while no clear arrives
  assert_edge_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!sense && raw_q && !clr) |=> raw_q);

  // R10: capture beats a clear in the same cycle
  assert_capture_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (!sense && hit && clr) |=> raw_q);

endmodule

// File: rtl/irq_trigger_capture.sv
`timescale 1ns/1ps
module irq_trigger_capture
  import trig_capture_pkg::*;
#(
  parameter int unsigned        N_LINES   = TC_LINES,
  parameter logic [N_LINES-1:0] SENSE_RST = TC_SENSE_RST[N_LINES-1:0],
  parameter logic [N_LINES-1:0] BOTH_RST  = TC_BOTH_RST[N_LINES-1:0],
  parameter logic [N_LINES-1:0] POL_RST   = TC_POL_RST[N_LINES-1:0]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               cfg_load,
  input  logic [N_LINES-1:0] cfg_sense_in,
  input  logic [N_LINES-1:0] cfg_both_in,
  input  logic [N_LINES-1:0] cfg_pol_in,
  input  logic [N_LINES-1:0] edge_clr,
  output logic [N_LINES-1:0] raw_pend,
  output logic [N_LINES-1:0] edge_stat
);

  logic [N_LINES-1:0] sense_q, both_q, pol_q;
  logic [N_LINES-1:0] raw_next;
  logic [N_LINES-1:0] sense_next;
  logic [N_LINES-1:0] edge_q;

  trig_cfg_regs #(
    .N_LINES  (N_LINES),
    .SENSE_RST(SENSE_RST),
    .BOTH_RST (BOTH_RST),
    .POL_RST  (POL_RST)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (cfg_load),
    .sense_in(cfg_sense_in),
    .both_in (cfg_both_in),
    .pol_in  (cfg_pol_in),
    .sense_q (sense_q),
    .both_q  (both_q),
    .pol_q   (pol_q)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    trig_line u_line (
      .clk  (clk),
      .rst  (rst),
      .lvl  (irq_lines[g]),
      .clr  (edge_clr[g]),
      .sense(sense_q[g]),
      .both (both_q[g]),
      .pol  (pol_q[g]),
      .raw_q(raw_pend[g]),
      .raw_d(raw_next[g])
    );
  end

  // edge view registered from next-state values so it lines up with raw_pend
  assign sense_next = cfg_load ? cfg_sense_in : sense_q;

  always_ff @(posedge clk) begin
    if (rst) edge_q <= '0;
    else     edge_q <= raw_next & ~sense_next;
  end

  assign edge_stat = edge_q;

  // R7: edge view agrees with the raw vector and the live sense vector
  assert_edge_view_R7: assert property (@(posedge clk) disable iff (rst)
    edge_stat == (raw_pend & ~sense_q));

  // R7: no level-sensed line ever shows in the edge view
  assert_edge_no_level_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_stat & sense_q) == '0);

endmodule

// File: tb/irq_trigger_capture_test.sv
`timescale 1ns/1ps
module irq_trigger_capture_test;
  localparam int N = 51;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] lines = '0, clr = '0, s_in = '0, b_in = '0, p_in = '0;
  logic         load = 1'b0;
  logic [N-1:0] raw_pend, edge_stat;

  irq_trigger_capture uut (
    .clk(clk), .rst(rst), .irq_lines(lines), .cfg_load(load),
    .cfg_sense_in(s_in), .cfg_both_in(b_in), .cfg_pol_in(p_in),
    .edge_clr(clr), .raw_pend(raw_pend), .edge_stat(edge_stat)
  );

  always #4 clk = ~clk;

  // reference model state, reset values from R8
  logic [N-1:0] m_raw = '0, m_prev = '0;
  logic [N-1:0] m_s = 51'h1F07FFF8FFFF;
  logic [N-1:0] m_b = 51'h00F800070000;
  logic [N-1:0] m_p = 51'h5F07FFF8FFFF;

  logic [N-1:0] q_raw[$];
  logic [N-1:0] q_es[$];
  string        q_tag[$];

  int  compared = 0, mismatched = 0;
  bit  done = 0;

  localparam logic [N-1:0] ALL = '1;

  function automatic logic [N-1:0] bv(input int i);
    logic [N-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic [N-1:0] in_v, input logic [N-1:0] c_v,
                      input logic ld, input logic [N-1:0] ns,
                      input logic [N-1:0] nb, input logic [N-1:0] np,
                      input string tag);
    @(negedge clk);
    lines = in_v; clr = c_v; load = ld; s_in = ns; b_in = nb; p_in = np;
    for (int i = 0; i < N; i++) begin
      logic cap;
      if (m_s[i])      cap = m_p[i] ? in_v[i] : !in_v[i];
      else if (m_b[i]) cap = in_v[i] != m_prev[i];
      else if (m_p[i]) cap = in_v[i] && !m_prev[i];
      else             cap = !in_v[i] && m_prev[i];
      if (m_s[i]) m_raw[i] = cap;
      else        m_raw[i] = cap | (m_raw[i] & !c_v[i]);
    end
    m_prev = in_v;
    if (ld) begin m_s = ns; m_b = nb; m_p = np; end
    q_raw.push_back(m_raw);
    q_es.push_back(m_raw & ~m_s);
    q_tag.push_back(tag);
  endtask

  task automatic step0(input logic [N-1:0] in_v, input logic [N-1:0] c_v,
                       input string tag);
    step(in_v, c_v, 1'b0, '0, '0, '0, tag);
  endtask

  // monitor: compares each queued item two ns after the edge that produced it
  always @(posedge clk) begin
    if (!rst && q_raw.size() > 0) begin
      logic [N-1:0] er, ee;
      string t;
      #2;
      er = q_raw.pop_front();
      ee = q_es.pop_front();
      t  = q_tag.pop_front();
      check(t, "raw_pend", raw_pend, er);
      check(t, "edge_stat R7", edge_stat, ee);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8", "raw_pend after reset", raw_pend, '0);
    check("R8", "edge_stat after reset", edge_stat, '0);

    step0('0, '0, "R8");                            // no spurious capture from reset levels
    step0(51'h0A5A5 | bv(44), '0, "R1");
    step0(51'h05A5A, '0, "R1");
    step0('0, '0, "R1");

    step0(bv(16), '0, "R2");                        // dual rise
    step0(bv(16), '0, "R9");                        // held
    step0(bv(16), bv(16), "R6");                    // cleared
    step0('0, '0, "R2");                            // dual fall
    step0('0, bv(16), "R6");

    step0(bv(45), '0, "R4");                        // rise ignored on falling line
    step0('0, '0, "R4");                            // fall captured
    step0('0, bv(45), "R6");
    step0(bv(46), '0, "R3");                        // rise captured
    step0('0, bv(46), "R3");                        // fall ignored, cleared

    step0(bv(17) | 51'hFFFF, '0, "R2");
    step0(bv(17) | 51'hFFFF, ALL, "R6");            // level lines untouched
    step0(bv(18), '0, "R2");
    step0('0, bv(18), "R10");                       // edge and clear collide
    step0('0, bv(18), "R6");

    step('0, '0, 1'b1, ALL, '0, '0, "R11");         // all level, active low
    step0('0, '0, "R11");
    step0(ALL, '0, "R1");
    step(ALL, '0, 1'b1, '0, '0, ALL, "R5");         // all rising edge
    step0(ALL, '0, "R5");                           // stored high level blocks capture
    step0('0, '0, "R5");
    step0(ALL, '0, "R3");
    step0(ALL, '0, "R9");
    step(ALL, ALL, 1'b1, '0, '0, '0, "R11");        // all falling edge
    step0('0, '0, "R4");
    step(ALL, '0, 1'b1, '0, ALL, '0, "R2");         // all dual
    step0('0, ALL, "R10");

    repeat (3) @(negedge clk);
    check("R11", "queue drained", q_raw.size() == 0 ? '0 : ALL, '0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule